// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Controller

This block collects the request lines of a group of peripheral interrupt sources and reduces them to a single request for a processor core. The sources feed ten vectors. A source and its vector are linked by a fixed mapping, and several sources may share one vector. Each vector carries one of three priority levels. Software chooses the level with a select bit, but each vector may use only two of the three levels. The controller reports the winning vector's code address and its level.

The controller keeps a record of the levels that are currently in service, so interrupts can nest. A new request goes to the core only when its level is strictly above the level now being serviced. The core answers with an acknowledge strobe, which takes the presented vector and records its level. It later sends a return strobe, which restores the level that was interrupted. The address taken at acknowledge is held on a separate output until the next accepted acknowledge.

Top module: `ivc_top`

## Requirements
- R1: The address of vector index v (0 to 9) is 03h + 8*v, so it ranges from 03h up to 4Bh, and it appears on `irq_vec_addr` while `irq_req` is high.
- R2: Levels are encoded none=0, low=1, high=2, highest=3. For vectors 0 and 1, `prio_sel[v]`=1 gives highest and 0 gives low. For vectors 2 to 9, `prio_sel[v]`=1 gives high and 0 gives low. The level of the presented vector appears on `irq_lvl`.
- R3: A vector is pending when any of its sources is high. The sources map to vectors as follows: 0-1 to 0, 2-3 to 1, 4-6 to 2, 7-8 to 3, 9 to 4, 10-11 to 5, 12 to 6, 13-14 to 7, 15-18 to 8, 19-20 to 9.
- R4: When several vectors are pending, one with a higher level is presented before any with a lower level.
- R5: Among pending vectors of the same level, the one with the smallest index (lowest address) is presented.
- R6: `irq_req` is high only when the best pending level is strictly greater than `svc_lvl`. With nothing in service, `svc_lvl` is 0, so a low request is accepted.
- R7: When `glob_en` is 0, `irq_req` stays low. When `vec_en[v]` is 0, vector v never takes part in the choice.
- R8: If `ack` is high while `irq_req` is high, then on the next cycle `svc_lvl` equals the accepted level and `ack_vec` equals the accepted address.
- R9: `reti` restores `svc_lvl` to the level that was in service before the most recent accepted acknowledge. `reti` with nothing in service has no effect.
- R10: `ack_vec` changes only after an accepted acknowledge. An `ack` while `irq_req` is low is ignored.
- R11: When `ack` and `reti` are both high in one cycle and the acknowledge is accepted, the acknowledge takes effect and the return is ignored.
- R12: After reset, `svc_lvl` is 0 and `ack_vec` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glob_en | input | 1 | Master enable for every request |
| vec_en | input | 10 | Per-vector enable |
| prio_sel | input | 10 | Per-vector level select |
| src_req | input | 21 | Source request lines |
| ack | input | 1 | Core takes the presented vector |
| reti | input | 1 | Core returns from the current handler |
| irq_req | output | 1 | Request to the core |
| irq_lvl | output | 2 | Level of the presented vector |
| irq_vec_addr | output | 8 | Address of the presented vector |
| svc_lvl | output | 2 | Level currently in service |
| ack_vec | output | 8 | Address captured at the last accepted acknowledge |

## Verification
Single sources, spread across the vectors, show that the source-to-vector mapping and the address formula are correct. Pairs of pending vectors are then tried in two ways. With different levels they show that level outranks index. With equal levels, once both low and once both high, they show that the lowest index wins. A nesting walk runs through all three levels and back out again. It also includes a pending request at the same level as the one in service, a return on an empty record, an acknowledge with no request, and a combined acknowledge and return. Together these separate strict greater-than acceptance from greater-or-equal acceptance, and a correct pop from a plain clear.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
    localparam int NUM_VEC   = 10;
    localparam int NUM_SRC   = 21;
    localparam int ADDR_W    = 8;
    localparam int ADDR_BASE = 3;
    localparam int ADDR_STEP = 8;
    localparam int TOP_VECS  = 2;
    localparam int VIDX_W    = $clog2(NUM_VEC);

    typedef enum logic [1:0] {
        LV_NONE = 2'd0,
        LV_LOW  = 2'd1,
        LV_HIGH = 2'd2,
        LV_TOP  = 2'd3
    } lvl_e;

    typedef struct packed {
        logic              valid;
        lvl_e              lvl;
        logic [VIDX_W-1:0] idx;
    } cand_t;

    // source index to vector index
    function automatic int src_vec(input int s);
        if (s < 2)       return 0;
        else if (s < 4)  return 1;
        else if (s < 7)  return 2;
        else if (s < 9)  return 3;
        else if (s < 10) return 4;
        else if (s < 12) return 5;
        else if (s < 13) return 6;
        else if (s < 15) return 7;
        else if (s < 19) return 8;
        else             return 9;
    endfunction

    function automatic logic [ADDR_W-1:0] vec_addr(input logic [VIDX_W-1:0] v);
        return ADDR_W'(ADDR_BASE) + ADDR_W'(ADDR_STEP) * ADDR_W'(v);
    endfunction

    function automatic lvl_e sel_lvl(input int v, input logic sel);
        if (!sel)           return LV_LOW;
        else if (v < TOP_VECS) return LV_TOP;
        else                return LV_HIGH;
    endfunction
endpackage

// File: rtl/ivc_src_merge.sv
module ivc_src_merge
    import ivc_pkg::*;
#(
    parameter int NV = NUM_VEC,
    parameter int NS = NUM_SRC
) (
    input  logic                glob_en,
    input  logic [NV-1:0]       vec_en,
    input  logic [NV-1:0]       prio_sel,
    input  logic [NS-1:0]       src_req,
    output logic [NV-1:0]       vec_pend,
    output lvl_e [NV-1:0]       vec_lvl
);
    for (genvar v = 0; v < NV; v++) begin : g_vec
        logic any_src;
        always_comb begin
            any_src = 1'b0;
            for (int s = 0; s < NS; s++) begin
                if (src_vec(s) == v) any_src = any_src | src_req[s];
            end
        end
        assign vec_pend[v] = glob_en & vec_en[v] & any_src;
        assign vec_lvl[v]  = sel_lvl(v, prio_sel[v]);
    end
endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter
    import ivc_pkg::*;
#(
    parameter int NV = NUM_VEC
) (
    input  logic [NV-1:0] vec_pend,
    input  lvl_e [NV-1:0] vec_lvl,
    output cand_t         winner
);
    // scan from the top index down; ">=" lets a lower index take a tie
    always_comb begin
        winner = '{valid: 1'b0, lvl: LV_NONE, idx: '0};
        for (int v = NV - 1; v >= 0; v--) begin
            if (vec_pend[v] && (vec_lvl[v] >= winner.lvl)) begin
                winner.valid = 1'b1;
                winner.lvl   = vec_lvl[v];
                winner.idx   = VIDX_W'(v);
            end
        end
    end
endmodule

// File: rtl/ivc_level_track.sv
module ivc_level_track
    import ivc_pkg::*;
#(
    parameter int NLV = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  lvl_e push_lvl,
    input  logic pop,
    output lvl_e cur_lvl
);
    // levels nest strictly upward, so the stack is a bit set
    logic [NLV-1:0] in_svc;

    always_comb begin
        cur_lvl = LV_NONE;
        for (int k = 0; k < NLV; k++) begin
            if (in_svc[k]) cur_lvl = lvl_e'(k + 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_svc <= '0;
        end else if (push) begin
            in_svc[int'(push_lvl) - 1] <= 1'b1;
        end else if (pop && (cur_lvl != LV_NONE)) begin
            in_svc[int'(cur_lvl) - 1] <= 1'b0;
        end
    end
endmodule

// File: rtl/ivc_top.sv
module ivc_top
    import ivc_pkg::*;
#(
    parameter int NV = NUM_VEC,
    parameter int NS = NUM_SRC,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          glob_en,
    input  logic [NV-1:0] vec_en,
    input  logic [NV-1:0] prio_sel,
    input  logic [NS-1:0] src_req,
    input  logic          ack,
    input  logic          reti,
    output logic          irq_req,
    output logic [1:0]    irq_lvl,
    output logic [AW-1:0] irq_vec_addr,
    output logic [1:0]    svc_lvl,
    output logic [AW-1:0] ack_vec
);
    logic [NV-1:0] vec_pend;
    lvl_e [NV-1:0] vec_lvl;
    cand_t         winner;
    lvl_e          cur_lvl;
    logic          take;

    ivc_src_merge #(.NV(NV), .NS(NS)) merge_i (
        .glob_en  (glob_en),
        .vec_en   (vec_en),
        .prio_sel (prio_sel),
        .src_req  (src_req),
        .vec_pend (vec_pend),
        .vec_lvl  (vec_lvl)
    );

    ivc_arbiter #(.NV(NV)) arb_i (
        .vec_pend (vec_pend),
        .vec_lvl  (vec_lvl),
        .winner   (winner)
    );

    assign irq_req      = winner.valid && (winner.lvl > cur_lvl);
    assign irq_lvl      = winner.lvl;
    assign irq_vec_addr = AW'(vec_addr(winner.idx));
    assign take         = ack && irq_req;

    ivc_level_track #(.NLV(3)) track_i (
        .clk      (clk),
        .rst      (rst),
        .push     (take),
        .push_lvl (winner.lvl),
        .pop      (reti),
        .cur_lvl  (cur_lvl)
    );

    assign svc_lvl = cur_lvl;

    always_ff @(posedge clk) begin
        if (rst)       ack_vec <= '0;
        else if (take) ack_vec <= irq_vec_addr;
    end
endmodule

// File: rtl/ivc_chk.sv
module ivc_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          glob_en,
    input logic          ack,
    input logic          reti,
    input logic          irq_req,
    input logic [1:0]    irq_lvl,
    input logic [AW-1:0] irq_vec_addr,
    input logic [1:0]    svc_lvl,
    input logic [AW-1:0] ack_vec
);
    p_addr_form_r1: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_vec_addr[2:0] == 3'b011 && irq_vec_addr <= AW'(8'h4B)));

    p_req_above_r6: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_lvl > svc_lvl));

    p_gate_off_r7: assert property (@(posedge clk) disable iff (rst)
        !glob_en |-> !irq_req);

    p_ack_push_r8: assert property (@(posedge clk) disable iff (rst)
        (ack && irq_req) |=> (svc_lvl == $past(irq_lvl) && ack_vec == $past(irq_vec_addr)));

    p_reti_pop_r9: assert property (@(posedge clk) disable iff (rst)
        (reti && !(ack && irq_req) && svc_lvl != 2'd0) |=> (svc_lvl < $past(svc_lvl)));

    p_reti_empty_r9: assert property (@(posedge clk) disable iff (rst)
        (reti && !ack && svc_lvl == 2'd0) |=> (svc_lvl == 2'd0));

    p_vec_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(ack && irq_req) |=> $stable(ack_vec));

    p_both_strobes_r11: assert property (@(posedge clk) disable iff (rst)
        (ack && reti && irq_req) |=> (svc_lvl > $past(svc_lvl)));
endmodule

bind ivc_top ivc_chk #(.AW(AW)) chk_i (.*);

// File: tb/ivc_top_tb_top.sv
module ivc_top_tb_top;
    localparam int NV = 10;
    localparam int NS = 21;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          glob_en = 1'b1;
    logic [NV-1:0] vec_en = '1;
    logic [NV-1:0] prio_sel = '0;
    logic [NS-1:0] src_req = '0;
    logic          ack = 1'b0;
    logic          reti = 1'b0;
    logic          irq_req;
    logic [1:0]    irq_lvl;
    logic [7:0]    irq_vec_addr;
    logic [1:0]    svc_lvl;
    logic [7:0]    ack_vec;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    ivc_top dut_i (.*);

    typedef struct {
        bit       req;
        bit [1:0] lvl;
        bit [7:0] addr;
        bit [1:0] svc;
        bit [7:0] av;
        string    tag;
    } exp_t;

    exp_t exp_q[$];
    event sample_ev;

    // reference model state
    int       m_stack[$];
    bit [7:0] m_av = 8'h00;

    function automatic int vec_of(int s);
        int bounds[10] = '{2, 4, 7, 9, 10, 12, 13, 15, 19, 21};
        for (int v = 0; v < 10; v++) if (s < bounds[v]) return v;
        return 9;
    endfunction

    function automatic int lvl_of(int v);
        if (!prio_sel[v]) return 1;
        return (v < 2) ? 3 : 2;
    endfunction

    // search level by level from the top, index ascending inside
    function automatic void model_pick(output bit found, output int lv, output int vi);
        bit pend[10];
        found = 0; lv = 0; vi = 0;
        for (int v = 0; v < 10; v++) pend[v] = 0;
        for (int s = 0; s < NS; s++)
            if (src_req[s] && glob_en && vec_en[vec_of(s)]) pend[vec_of(s)] = 1;
        for (int l = 3; l >= 1 && !found; l--)
            for (int v = 0; v < 10 && !found; v++)
                if (pend[v] && lvl_of(v) == l) begin found = 1; lv = l; vi = v; end
    endfunction

    function automatic int m_top();
        return (m_stack.size() == 0) ? 0 : m_stack[$];
    endfunction

    task automatic expect_now(input string tag);
        exp_t e;
        bit f; int lv; int vi;
        model_pick(f, lv, vi);
        e.req  = f && (lv > m_top());
        e.lvl  = 2'(lv);
        e.addr = 8'(3 + 8 * vi);
        e.svc  = 2'(m_top());
        e.av   = m_av;
        e.tag  = tag;
        exp_q.push_back(e);
        -> sample_ev;
        #1;
    endtask

    // monitor: pops expectations and compares against the ports
    initial begin
        forever begin
            @(sample_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                bit bad;
                e = exp_q.pop_front();
                checks++;
                bad = 0;
                if (irq_req !== e.req) begin
                    $display("FAIL %s irq_req actual=%0b expected=%0b", e.tag, irq_req, e.req); bad = 1;
                end
                if (e.req && irq_lvl !== e.lvl) begin
                    $display("FAIL %s irq_lvl actual=%0d expected=%0d", e.tag, irq_lvl, e.lvl); bad = 1;
                end
                if (e.req && irq_vec_addr !== e.addr) begin
                    $display("FAIL %s irq_vec_addr actual=%h expected=%h", e.tag, irq_vec_addr, e.addr); bad = 1;
                end
                if (svc_lvl !== e.svc) begin
                    $display("FAIL %s svc_lvl actual=%0d expected=%0d", e.tag, svc_lvl, e.svc); bad = 1;
                end
                if (ack_vec !== e.av) begin
                    $display("FAIL %s ack_vec actual=%h expected=%h", e.tag, ack_vec, e.av); bad = 1;
                end
                if (bad) failures++;
            end
        end
    end

    // drive strobes for one cycle, update model at the edge, check both sides
    task automatic cycle(input bit a, input bit r, input string tag);
        bit f; int lv; int vi;
        ack = a; reti = r;
        expect_now({tag, "_pre"});
        model_pick(f, lv, vi);
        if (a && f && lv > m_top()) begin
            m_stack.push_back(lv);
            m_av = 8'(3 + 8 * vi);
        end else if (r && m_stack.size() > 0) begin
            void'(m_stack.pop_back());
        end
        @(negedge clk);
        ack = 0; reti = 0;
        expect_now({tag, "_post"});
    endtask

    task automatic set_src(input int s);
        src_req = '0;
        src_req[s] = 1'b1;
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        expect_now("R12_reset");

        // R1 R3: single sources across vectors
        set_src(0);  expect_now("R3_src0_R1");
        set_src(3);  expect_now("R3_src3_R1");
        set_src(9);  expect_now("R3_src9_R1");
        set_src(16); expect_now("R3_src16_R1");
        set_src(20); expect_now("R3_src20_R1");
        set_src(12); expect_now("R3_src12_R1");

        // R2: level select
        prio_sel[0] = 1; set_src(1);  expect_now("R2_v0_top");
        prio_sel[5] = 1; set_src(11); expect_now("R2_v5_high");
        prio_sel = '0;

        // R4: level outranks index
        prio_sel[8] = 1; src_req = '0; src_req[4] = 1; src_req[15] = 1;
        expect_now("R4_high_over_low");
        prio_sel[0] = 1; src_req[0] = 1;
        expect_now("R4_top_over_high");
        prio_sel = '0;

        // R5: ties go to lowest index
        src_req = '0; src_req[7] = 1; src_req[10] = 1;
        expect_now("R5_low_tie");
        prio_sel[3] = 1; prio_sel[5] = 1;
        expect_now("R5_high_tie");
        prio_sel = '0;

        // R7: gating
        glob_en = 0; expect_now("R7_global_off");
        glob_en = 1; vec_en[3] = 0; expect_now("R7_vec_masked");
        vec_en = '1;

        // R10: ack with no request ignored
        src_req = '0;
        cycle(1, 0, "R10_idle_ack");

        // R8 R6 R9: nesting walk
        set_src(10);
        cycle(1, 0, "R8_ack_low");
        expect_now("R6_same_level_blocked");
        prio_sel[8] = 1; src_req[15] = 1;
        cycle(1, 0, "R8_ack_high_R6");
        prio_sel[0] = 1; src_req[0] = 1;
        cycle(1, 0, "R8_ack_top");
        cycle(1, 0, "R10_ack_blocked");
        cycle(0, 1, "R9_pop_to_high");
        cycle(0, 1, "R9_pop_to_low");
        cycle(0, 1, "R9_pop_to_none");
        src_req = '0;
        cycle(0, 1, "R9_reti_empty");

        // R11: ack and return together
        prio_sel = '0; set_src(9);
        cycle(1, 0, "R11_setup_low");
        prio_sel[7] = 1; src_req[13] = 1;
        cycle(1, 1, "R11_both");
        src_req = '0;
        cycle(0, 1, "R11_unwind1");
        cycle(0, 1, "R11_unwind2");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule